// File: doc/BRIEF.md
# Octal registered bus transceiver

This block joins two 8-bit bidirectional buses, called A and B, without inverting the data. Each direction of transfer owns a storage register with its own capture strobe. For each direction a select picks whether the opposite bus receives the live input of the source bus or the value held in that direction's register. A per-direction drive enable decides whether the opposite bus is driven at all. The B-side enable is active high and the A-side enable is active low.

Each bus is modelled as three ports: an input that carries what is seen on the wire, an output value, and an output enable. No tri-state nets exist inside the block. A pad ring or a bus resolver outside combines them. All logic runs in one clock domain. The capture strobes are sampled on `clk`, and a register loads on the first clock edge at which its strobe is sampled high after having been sampled low.

A configuration in which both buses would be driven from each other's live inputs would form a combinational loop. The block flags that configuration on an error output and drives neither bus while it lasts. The active-low reset stands in for power-up: while it is low, neither bus is driven, and both registers clear on every clock edge. The data path has no valid/ready handshake, because the link is a level-controlled bus connection and never holds data back. Every pin is a plain level.

Top module: `xcvr_bus_link`

## Requirements
- R1: When B is driven and `ab_sel_stored` is 0, `b_out` equals `a_in` bit for bit, with no inversion and in the same cycle.
- R2: When A is driven and `ba_sel_stored` is 0, `a_out` equals `b_in` bit for bit, with no inversion and in the same cycle.
- R3: When B is driven and `ab_sel_stored` is 1, `b_out` shows the A-to-B register. When A is driven and `ba_sel_stored` is 1, `a_out` shows the B-to-A register.
- R4: Each register loads only on the first clock edge at which its strobe is sampled high after it was sampled low. A strobe held high loads nothing more. Loading works whatever the drive enables are, including when both buses are undriven.
- R5: A register captures the value present on its source bus. When the block itself drives that bus, the register takes the driven value and not the external input.
- R6: `b_oe` is 1 exactly when `b_drive_en` is 1, and `a_oe` is 1 exactly when `a_drive_n` is 0, in both cases outside reset and outside a loop. A bus output that is not driven reads all zeros.
- R7: With both buses driven and both selects set to 1, both buses carry stored data at the same time, and holding the strobes steady while the inputs change leaves both outputs unchanged.
- R8: When `b_drive_en` is 1, `a_drive_n` is 0 and both selects are 0, `loop_err` is 1 and neither bus is driven. Otherwise `loop_err` is 0.
- R9: While `rst_n` is 0, neither bus is driven. Both registers read zero once the reset has been held for at least one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled and registers load on its rising edge |
| rst_n | input | 1 | Active-low reset, standing in for power-up |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value the block drives onto bus A (zero when not driving) |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value the block drives onto bus B (zero when not driving) |
| b_oe | output | 1 | Drive enable for bus B |
| ab_strobe | input | 1 | Capture strobe for the A-to-B register (rising sample loads) |
| ba_strobe | input | 1 | Capture strobe for the B-to-A register (rising sample loads) |
| ab_sel_stored | input | 1 | 1: B gets the A-to-B register; 0: B gets live A |
| ba_sel_stored | input | 1 | 1: A gets the B-to-A register; 0: A gets live B |
| b_drive_en | input | 1 | Active-high request to drive bus B |
| a_drive_n | input | 1 | Active-low request to drive bus A |
| loop_err | output | 1 | Live-to-live loop configuration detected |

## Verification
On every cycle, the assertions check the following: the enable polarities, the zero value on undriven outputs, the loop shutdown, and the hi-Z state in reset. They also check that each register loads the bus value exactly on a sampled rising strobe and holds otherwise, and that the driven data follows the live or stored select. Only the bench's scenarios show the following: that a register loaded with the bus in input mode really returns the expected byte later, that a register on a driven bus picks up the driven value over a conflicting external one, and that stored data on both buses survives steady strobes while the inputs change. The bench also shows that a reset in mid-run clears values loaded earlier, and that pulsing both strobes with both buses driven from storage swaps the two registers.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int LINK_W = 8;

  function automatic logic loop_cfg(input logic b_req, input logic a_req_n,
                                    input logic ab_stored, input logic ba_stored);
    return b_req & ~a_req_n & ~ab_stored & ~ba_stored;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = xcvr_pkg::LINK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] bus_seen,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic load;

  assign load = strobe & ~strobe_q;

  // strobe history follows the pin even in reset, so a strobe held high
  // through reset is not taken as a fresh edge
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= bus_seen;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = xcvr_pkg::LINK_W
) (
  input  logic         drive_ok,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic [W-1:0] pick;

  assign pick = sel_stored ? stored : live;
  assign oe   = drive_ok;
  assign dout = drive_ok ? pick : '0;
endmodule

// File: rtl/xcvr_bus_link.sv
module xcvr_bus_link #(
  parameter int W = xcvr_pkg::LINK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_strobe,
  input  logic         ba_strobe,
  input  logic         ab_sel_stored,
  input  logic         ba_sel_stored,
  input  logic         b_drive_en,
  input  logic         a_drive_n,
  output logic         loop_err
);
  logic [W-1:0] ab_q, ba_q;
  logic [W-1:0] a_seen, b_seen;
  logic         ab_ok, ba_ok;

  assign loop_err = xcvr_pkg::loop_cfg(b_drive_en, a_drive_n, ab_sel_stored, ba_sel_stored);
  assign ab_ok    = rst_n & b_drive_en & ~loop_err;
  assign ba_ok    = rst_n & ~a_drive_n & ~loop_err;

  // what each register sees is the wire value, which is our own drive when enabled
  assign a_seen = a_oe ? a_out : a_in;
  assign b_seen = b_oe ? b_out : b_in;

  xcvr_store #(.W(W)) u_store_ab (
    .clk(clk), .rst_n(rst_n), .strobe(ab_strobe), .bus_seen(a_seen), .q(ab_q)
  );

  xcvr_store #(.W(W)) u_store_ba (
    .clk(clk), .rst_n(rst_n), .strobe(ba_strobe), .bus_seen(b_seen), .q(ba_q)
  );

  xcvr_lane #(.W(W)) u_lane_ab (
    .drive_ok(ab_ok), .sel_stored(ab_sel_stored), .live(a_in), .stored(ab_q),
    .dout(b_out), .oe(b_oe)
  );

  xcvr_lane #(.W(W)) u_lane_ba (
    .drive_ok(ba_ok), .sel_stored(ba_sel_stored), .live(b_in), .stored(ba_q),
    .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/xcvr_bus_link_chk.sv
module xcvr_bus_link_chk #(
  parameter int W = xcvr_pkg::LINK_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         ab_strobe,
  input logic         ba_strobe,
  input logic         ab_sel_stored,
  input logic         ba_sel_stored,
  input logic         b_drive_en,
  input logic         a_drive_n,
  input logic         loop_err,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q
);
  a_r1_live_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !ab_sel_stored) |-> b_out == a_in);
  a_r2_live_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && !ba_sel_stored) |-> a_out == b_in);
  a_r3_stored_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && ab_sel_stored) |-> b_out == ab_q);
  a_r3_stored_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && ba_sel_stored) |-> a_out == ba_q);
  a_r4_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_strobe) |=> ab_q == $past(a_oe ? a_out : a_in));
  a_r4_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ba_strobe) |=> ba_q == $past(b_oe ? b_out : b_in));
  a_r4_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ab_strobe) |=> $stable(ab_q));
  a_r4_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ba_strobe) |=> $stable(ba_q));
  a_r6_b_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe |-> b_drive_en);
  a_r6_a_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe |-> !a_drive_n);
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_oe |-> a_out == '0) and (!b_oe |-> b_out == '0));
  a_r8_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |-> (!a_oe && !b_oe));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_hiz: assert (!a_oe && !b_oe);
    end
  end
endmodule

bind xcvr_bus_link xcvr_bus_link_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_strobe(ab_strobe),
  .ba_strobe(ba_strobe), .ab_sel_stored(ab_sel_stored),
  .ba_sel_stored(ba_sel_stored), .b_drive_en(b_drive_en),
  .a_drive_n(a_drive_n), .loop_err(loop_err), .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/tb_xcvr_bus_link.sv
module tb_xcvr_bus_link;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe, loop_err;
  logic       ab_strobe = 1'b0, ba_strobe = 1'b0;
  logic       ab_sel_stored = 1'b0, ba_sel_stored = 1'b0;
  logic       b_drive_en = 1'b0, a_drive_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model of the two registers
  logic [7:0] m_ab = 8'h00, m_ba = 8'h00;

  always #2.5 clk = ~clk;

  xcvr_bus_link dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_strobe(ab_strobe),
    .ba_strobe(ba_strobe), .ab_sel_stored(ab_sel_stored),
    .ba_sel_stored(ba_sel_stored), .b_drive_en(b_drive_en),
    .a_drive_n(a_drive_n), .loop_err(loop_err)
  );

  function automatic logic e_loop();
    return b_drive_en && !a_drive_n && !ab_sel_stored && !ba_sel_stored;
  endfunction
  function automatic logic e_boe();
    return rst_n && b_drive_en && !e_loop();
  endfunction
  function automatic logic e_aoe();
    return rst_n && !a_drive_n && !e_loop();
  endfunction
  function automatic logic [7:0] e_bout();
    return e_boe() ? (ab_sel_stored ? m_ab : a_in) : 8'h00;
  endfunction
  function automatic logic [7:0] e_aout();
    return e_aoe() ? (ba_sel_stored ? m_ba : b_in) : 8'h00;
  endfunction

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "a_out", a_out, e_aout());
    cmp(tag, "a_oe", {7'd0, a_oe}, {7'd0, e_aoe()});
    cmp(tag, "b_out", b_out, e_bout());
    cmp(tag, "b_oe", {7'd0, b_oe}, {7'd0, e_boe()});
    cmp(tag, "loop_err", {7'd0, loop_err}, {7'd0, e_loop()});
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic set_ctrl(logic bdrv, logic adrvn, logic sab, logic sba);
    @(negedge clk);
    b_drive_en = bdrv; a_drive_n = adrvn; ab_sel_stored = sab; ba_sel_stored = sba;
    #1;
  endtask

  // one strobe pulse on either or both directions; model captures wire values
  task automatic pulse(bit do_ab, bit do_ba, string tag);
    logic [7:0] nab, nba;
    @(negedge clk);
    ab_strobe = do_ab; ba_strobe = do_ba;
    #1;
    nab = e_aoe() ? e_aout() : a_in;
    nba = e_boe() ? e_bout() : b_in;
    @(posedge clk);
    if (do_ab) m_ab = nab;
    if (do_ba) m_ba = nba;
    @(negedge clk);
    ab_strobe = 1'b0; ba_strobe = 1'b0;
    #1;
    check_all(tag);
  endtask

  task automatic t_reset_state();
    // R9: drive requests present while reset is low
    b_drive_en = 1'b1; a_drive_n = 1'b0; ab_sel_stored = 1'b1; ba_sel_stored = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R9");
    cmp("R9", "b_oe in reset", {7'd0, b_oe}, 8'd0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check_all("R9");
    cmp("R9", "b_out cleared", b_out, 8'h00);
  endtask

  task automatic t_live_ab();
    logic [7:0] pats[5] = '{8'h00, 8'hA5, 8'h5A, 8'hFF, 8'h3C};
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    foreach (pats[i]) begin
      @(negedge clk) a_in = pats[i];
      #1;
      check_all("R1");
      cmp("R1", "b_out live", b_out, pats[i]);
    end
  endtask

  task automatic t_live_ba();
    logic [7:0] pats[4] = '{8'h81, 8'h7E, 8'h01, 8'hC3};
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    foreach (pats[i]) begin
      @(negedge clk) b_in = pats[i];
      #1;
      check_all("R2");
      cmp("R2", "a_out live", a_out, pats[i]);
    end
  endtask

  task automatic t_enables();
    for (int k = 0; k < 4; k++) begin
      set_ctrl(k[0], k[1], 1'b1, 1'b0);
      check_all("R6");
    end
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    cmp("R6", "idle a_out zero", a_out, 8'h00);
    cmp("R6", "idle b_out zero", b_out, 8'h00);
  endtask

  task automatic t_store();
    // both buses undriven: inputs only, registers still load (R4)
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk) a_in = 8'h96; b_in = 8'h69;
    pulse(1'b1, 1'b0, "R4");
    pulse(1'b0, 1'b1, "R4");
    // held strobe loads nothing further
    @(negedge clk) ab_strobe = 1'b1;
    #1;
    @(posedge clk) m_ab = a_in;
    @(negedge clk) a_in = 8'h0F;
    repeat (3) @(posedge clk);
    @(negedge clk) ab_strobe = 1'b0;
    // read both registers through the stored selects (R3)
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    check_all("R3");
    cmp("R4", "held strobe no reload", b_out, 8'h96);
    cmp("R3", "a_out stored", a_out, 8'h69);
  endtask

  task automatic t_driven_capture();
    // A driven with live B; external A input disagrees
    set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk) b_in = 8'hC3; a_in = 8'h11;
    pulse(1'b1, 1'b0, "R5");
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    check_all("R5");
    cmp("R5", "driven value captured", b_out, 8'hC3);
  endtask

  task automatic t_both_stored();
    // load distinct values first with buses as inputs
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk) a_in = 8'h24; b_in = 8'hB7;
    pulse(1'b1, 1'b1, "R4");
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    check_all("R7");
    @(negedge clk) ab_strobe = 1'b1; ba_strobe = 1'b1; a_in = 8'hEE; b_in = 8'hDD;
    @(posedge clk);
    m_ab = 8'hB7; m_ba = 8'h24;  // each register sees the other's driven value
    @(negedge clk) a_in = 8'h12; b_in = 8'h34;
    repeat (2) @(posedge clk);
    settle();
    check_all("R7");
    cmp("R7", "b_out swapped", b_out, 8'hB7);
    cmp("R7", "a_out swapped", a_out, 8'h24);
    @(negedge clk) ab_strobe = 1'b0; ba_strobe = 1'b0;
  endtask

  task automatic t_loop();
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    check_all("R8");
    cmp("R8", "loop flag", {7'd0, loop_err}, 8'd1);
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
    check_all("R8");
    cmp("R8", "loop cleared", {7'd0, loop_err}, 8'd0);
  endtask

  task automatic t_reset_clears();
    set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk) a_in = 8'h5C; b_in = 8'hA3;
    pulse(1'b1, 1'b1, "R4");
    @(negedge clk) rst_n = 1'b0; b_drive_en = 1'b1; a_drive_n = 1'b0;
    ab_sel_stored = 1'b1; ba_sel_stored = 1'b1;
    #1;
    check_all("R9");
    repeat (2) @(posedge clk);
    m_ab = 8'h00; m_ba = 8'h00;
    @(negedge clk) rst_n = 1'b1;
    #1;
    check_all("R9");
    cmp("R9", "ab register cleared", b_out, 8'h00);
    cmp("R9", "ba register cleared", a_out, 8'h00);
  endtask

  initial begin
    t_reset_state();
    t_live_ab();
    t_live_ba();
    t_enables();
    t_store();
    t_driven_capture();
    t_both_stored();
    t_loop();
    t_reset_clears();
    settle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule